// File: doc/BRIEF.md
# Multi-Cycle CPU Main Controller

This block is the central sequencer of a non-pipelined 32-bit processor that shares one ALU and one memory port across the steps of each instruction. It watches the opcode, function code and rt field held in the instruction register. Every clock it drives the enables and multiplexer selects of the surrounding datapath. Every instruction starts with a memory read at the program counter, a wait cycle for the synchronous RAM, and a capture into the instruction register while the PC advances by 4. A decode step follows in which the ALU adds the shifted, sign-extended offset to the PC so that a branch target is already waiting in the ALU output register. After decode the sequence forks by instruction class.

The block emits a small ALU operation class code. A separate ALU control decoder turns that code, together with the opcode and function field, into the real ALU operation. The block also merges its conditional PC enable with the ALU's branch-taken flag into a single PC load strobe. A halt opcode parks the controller in a state that writes nothing until reset. The block has no data streams: every pin is a plain level control or status signal, sampled or changed on the rising clock edge.

Top module: `mc_main_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show the fetch step: `mem_rd`=1 and `addr_from_alu`=0, with every other enable 0, `srcb_sel`=0, `pc_src`=0, `alu_op`=0 and `wb_sel`=0.
- R2: Every instruction begins with three steps. The first is fetch. The second is a wait step with `ir_wr`=1, `pc_wr`=1, `srca_is_reg`=0, `srcb_sel`=1 (constant 4), `alu_op`=0 (add) and `pc_src`=0 (live ALU result). The third is decode, with `srca_is_reg`=0, `srcb_sel`=3 (immediate shifted by 2), `imm_signed`=1 and `alu_op`=0.
- R3: For opcode 0x00 with a function code other than 0x08, 0x10, 0x12, 0x18 or 0x19, the controller executes with `srca_is_reg`=1, `srcb_sel`=0 and `alu_op`=1 (function-driven). It then writes back with `reg_wr`=1, `dst_is_rd`=1 and `wb_sel`=0 (ALU output register), and returns to fetch.
- R4: For opcodes 0x09, 0x10, 0x0A, 0x0B, 0x0C, 0x0D and 0x0E, the controller executes with `srca_is_reg`=1, `srcb_sel`=2 and `alu_op`=2 (opcode-driven). It then writes back to rt (`reg_wr`=1, `dst_is_rd`=0, `wb_sel`=0). `imm_signed` is 0 during execute for 0x0C, 0x0D and 0x0E, and 1 for the others.
- R5: A load (0x23) runs through an address step (`srca_is_reg`=1, `srcb_sel`=2, `imm_signed`=1, `alu_op`=0). Next comes a read step (`mem_rd`=1, `addr_from_alu`=1), then a wait step (`addr_from_alu`=1 only). It ends with write-back to rt with `wb_sel`=1 (memory data register).
- R6: A store (0x2B) runs through the same address step and then a single write step (`mem_wr`=1, `addr_from_alu`=1). It writes no register.
- R7: Opcodes 0x04 to 0x07, and opcode 0x01 with rt equal to 0 or 1, take one compare step: `srca_is_reg`=1, `srcb_sel`=0, `alu_op`=3, `pc_wr_cond`=1, `pc_src`=1 (ALU output register). Opcode 0x01 with any other rt is unrecognised (R13).
- R8: A jump (0x02) takes one step with `pc_wr`=1 and `pc_src`=2 (jump target).
- R9: A jump-and-link (0x03) takes one step with `pc_wr`=1, `pc_src`=2, `reg_wr`=1, `dst_link31`=1 and `wb_sel`=4 (the already advanced PC).
- R10: A register jump (opcode 0x00, function 0x08) takes one step with `srca_is_reg`=1, `alu_op`=4 (pass A), `pc_wr`=1 and `pc_src`=0.
- R11: Function codes 0x18 and 0x19 take one step with `srca_is_reg`=1, `srcb_sel`=0, `alu_op`=1, `hi_ld`=1 and `lo_ld`=1. Function 0x10 takes one write-back step with `wb_sel`=3 (HI), and 0x12 takes one with `wb_sel`=2 (LO). Both use `reg_wr`=1 and `dst_is_rd`=1.
- R12: Opcode 0x3F leads, after decode, to a state in which every output is 0 and which only reset leaves.
- R13: Any other opcode returns straight from decode to fetch and asserts no write enable on the way.
- R14: `pc_load` equals `pc_wr` OR (`pc_wr_cond` AND `br_taken`). `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| rt_sel | input | 5 | rt field of the instruction register |
| br_taken | input | 1 | Branch condition from the ALU |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if branch taken |
| pc_load | output | 1 | Combined PC enable |
| addr_from_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register enable |
| reg_wr | output | 1 | Register file write |
| dst_is_rd | output | 1 | Destination rd (1) or rt (0) |
| dst_link31 | output | 1 | Destination forced to register 31 |
| imm_signed | output | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| srca_is_reg | output | 1 | ALU A from register A (1) or PC (0) |
| srcb_sel | output | 2 | ALU B: 0 B, 1 four, 2 immediate, 3 immediate shifted by 2 |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |
| alu_op | output | 3 | 0 add, 1 by function, 2 by opcode, 3 compare, 4 pass A |
| wb_sel | output | 3 | 0 ALU out, 1 memory data, 2 LO, 3 HI, 4 PC |
| hi_ld | output | 1 | HI register enable |
| lo_ld | output | 1 | LO register enable |

## Verification
The assertions watch properties that hold in every cycle. A fetch read is always followed by the instruction capture. A load's memory read is followed by a wait and then a write-back from the data register. A link write always comes together with a PC write. HI and LO load together and never with a register write. Halt is never left. Memory reads and writes exclude each other, and the PC strobe follows its definition. Only the bench scenarios can show that each opcode and function code gets its exact step list and select values. The bench also covers the zero-extension of logical immediates, rejection of an unknown rt code under opcode 0x01, unknown opcodes falling back to fetch, and recovery from halt through reset.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  parameter int OPC_W   = 6;
  parameter int FUN_W   = 6;
  parameter int RTF_W   = 5;
  parameter int SRCB_W  = 2;
  parameter int PCS_W   = 2;
  parameter int ALUOP_W = 3;
  parameter int WBS_W   = 3;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00, OP_REGIMM = 6'h01, OP_J = 6'h02,
    OP_JAL = 6'h03, OP_BEQ = 6'h04, OP_BGTZ = 6'h07, OP_ADDIU = 6'h09,
    OP_SLTI = 6'h0A, OP_SLTIU = 6'h0B, OP_ANDI = 6'h0C, OP_ORI = 6'h0D,
    OP_XORI = 6'h0E, OP_SUBIU = 6'h10, OP_LW = 6'h23, OP_SW = 6'h2B, OP_HALT = 6'h3F;
  localparam logic [FUN_W-1:0] FN_JR = 6'h08, FN_MFHI = 6'h10, FN_MFLO = 6'h12,
    FN_MULT = 6'h18, FN_MULTU = 6'h19;

  localparam logic [SRCB_W-1:0] SB_REG = 2'd0, SB_FOUR = 2'd1, SB_IMM = 2'd2, SB_IMMSH = 2'd3;
  localparam logic [PCS_W-1:0]  PS_ALU = 2'd0, PS_ALUOUT = 2'd1, PS_JUMP = 2'd2;
  localparam logic [ALUOP_W-1:0] AO_ADD = 3'd0, AO_FUNC = 3'd1, AO_IMM = 3'd2,
    AO_CMP = 3'd3, AO_PASSA = 3'd4;
  localparam logic [WBS_W-1:0] WB_ALUOUT = 3'd0, WB_MDR = 3'd1, WB_LO = 3'd2,
    WB_HI = 3'd3, WB_PC = 3'd4;

  typedef enum logic [4:0] {
    S_FETCH, S_FWAIT, S_DECODE, S_EXEC_R, S_WB_R, S_MULT, S_MFHI, S_MFLO, S_JR,
    S_EXEC_I, S_WB_I, S_ADDR, S_LW_RD, S_LW_WAIT, S_LW_WB, S_SW_WR, S_BRANCH,
    S_JUMP, S_JAL, S_HALT
  } state_t;

  typedef enum logic [3:0] {
    C_RALU, C_MULT, C_MFHI, C_MFLO, C_JR, C_IMM, C_LW, C_SW, C_BR, C_J, C_JAL,
    C_HALT, C_BAD
  } iclass_t;

  typedef struct packed {
    logic pc_wr;
    logic pc_wr_cond;
    logic iord;
    logic mem_rd;
    logic mem_wr;
    logic ir_wr;
    logic reg_wr;
    logic dst_rd;
    logic link31;
    logic imm_signed;
    logic srca_reg;
    logic [SRCB_W-1:0]  srcb;
    logic [PCS_W-1:0]   pc_src;
    logic [ALUOP_W-1:0] alu_op;
    logic [WBS_W-1:0]   wb_sel;
    logic hi_ld;
    logic lo_ld;
  } ctrl_t;
endpackage

// File: rtl/mc_classify.sv
module mc_classify
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FUN_W-1:0] funct,
  input  logic [RTF_W-1:0] rt_sel,
  output iclass_t          cls,
  output logic             zext
);
  always_comb begin
    zext = 1'b0;
    cls  = C_BAD;
    unique case (opcode)
      OP_RTYPE: begin
        unique case (funct)
          FN_JR:             cls = C_JR;
          FN_MFHI:           cls = C_MFHI;
          FN_MFLO:           cls = C_MFLO;
          FN_MULT, FN_MULTU: cls = C_MULT;
          default:           cls = C_RALU;
        endcase
      end
      OP_ADDIU, OP_SUBIU, OP_SLTI, OP_SLTIU: cls = C_IMM;
      OP_ANDI, OP_ORI, OP_XORI: begin
        cls  = C_IMM;
        zext = 1'b1;
      end
      OP_LW:     cls = C_LW;
      OP_SW:     cls = C_SW;
      OP_J:      cls = C_J;
      OP_JAL:    cls = C_JAL;
      OP_HALT:   cls = C_HALT;
      OP_REGIMM: cls = (rt_sel == '0 || rt_sel == RTF_W'(1)) ? C_BR : C_BAD;
      default:   cls = (opcode >= OP_BEQ && opcode <= OP_BGTZ) ? C_BR : C_BAD;
    endcase
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mc_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t cls,
  output state_t  state
);
  state_t nxt;

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_FWAIT;
      S_FWAIT:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (cls)
          C_RALU:       nxt = S_EXEC_R;
          C_MULT:       nxt = S_MULT;
          C_MFHI:       nxt = S_MFHI;
          C_MFLO:       nxt = S_MFLO;
          C_JR:         nxt = S_JR;
          C_IMM:        nxt = S_EXEC_I;
          C_LW, C_SW:   nxt = S_ADDR;
          C_BR:         nxt = S_BRANCH;
          C_J:          nxt = S_JUMP;
          C_JAL:        nxt = S_JAL;
          C_HALT:       nxt = S_HALT;
          default:      nxt = S_FETCH;
        endcase
      end
      S_EXEC_R:  nxt = S_WB_R;
      S_EXEC_I:  nxt = S_WB_I;
      S_ADDR:    nxt = (cls == C_LW) ? S_LW_RD : S_SW_WR;
      S_LW_RD:   nxt = S_LW_WAIT;
      S_LW_WAIT: nxt = S_LW_WB;
      S_HALT:    nxt = S_HALT;
      default:   nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/mc_outdec.sv
module mc_outdec
  import mc_ctrl_pkg::*;
(
  input  state_t state,
  input  logic   zext,
  output ctrl_t  cw
);
  always_comb begin
    cw = '0;
    unique case (state)
      S_FETCH: cw.mem_rd = 1'b1;
      S_FWAIT: begin
        cw.ir_wr = 1'b1;
        cw.pc_wr = 1'b1;
        cw.srcb  = SB_FOUR;
      end
      S_DECODE: begin
        cw.srcb       = SB_IMMSH;
        cw.imm_signed = 1'b1;
      end
      S_EXEC_R: begin
        cw.srca_reg = 1'b1;
        cw.alu_op   = AO_FUNC;
      end
      S_MULT: begin
        cw.srca_reg = 1'b1;
        cw.alu_op   = AO_FUNC;
        cw.hi_ld    = 1'b1;
        cw.lo_ld    = 1'b1;
      end
      S_WB_R, S_MFHI, S_MFLO: begin
        cw.reg_wr = 1'b1;
        cw.dst_rd = 1'b1;
        cw.wb_sel = (state == S_MFHI) ? WB_HI : (state == S_MFLO) ? WB_LO : WB_ALUOUT;
      end
      S_JR: begin
        cw.srca_reg = 1'b1;
        cw.alu_op   = AO_PASSA;
        cw.pc_wr    = 1'b1;
      end
      S_EXEC_I: begin
        cw.srca_reg   = 1'b1;
        cw.srcb       = SB_IMM;
        cw.imm_signed = !zext;
        cw.alu_op     = AO_IMM;
      end
      S_WB_I:  cw.reg_wr = 1'b1;
      S_ADDR: begin
        cw.srca_reg   = 1'b1;
        cw.srcb       = SB_IMM;
        cw.imm_signed = 1'b1;
      end
      S_LW_RD: begin
        cw.mem_rd = 1'b1;
        cw.iord   = 1'b1;
      end
      S_LW_WAIT: cw.iord = 1'b1;
      S_LW_WB: begin
        cw.reg_wr = 1'b1;
        cw.wb_sel = WB_MDR;
      end
      S_SW_WR: begin
        cw.mem_wr = 1'b1;
        cw.iord   = 1'b1;
      end
      S_BRANCH: begin
        cw.srca_reg   = 1'b1;
        cw.alu_op     = AO_CMP;
        cw.pc_wr_cond = 1'b1;
        cw.pc_src     = PS_ALUOUT;
      end
      S_JUMP: begin
        cw.pc_wr  = 1'b1;
        cw.pc_src = PS_JUMP;
      end
      S_JAL: begin
        cw.pc_wr  = 1'b1;
        cw.pc_src = PS_JUMP;
        cw.reg_wr = 1'b1;
        cw.link31 = 1'b1;
        cw.wb_sel = WB_PC;
      end
      default: cw = '0;
    endcase
  end
endmodule

// File: rtl/mc_main_ctrl.sv
module mc_main_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUN_W-1:0]   funct,
  input  logic [RTF_W-1:0]   rt_sel,
  input  logic               br_taken,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic               pc_load,
  output logic               addr_from_alu,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_wr,
  output logic               reg_wr,
  output logic               dst_is_rd,
  output logic               dst_link31,
  output logic               imm_signed,
  output logic               srca_is_reg,
  output logic [SRCB_W-1:0]  srcb_sel,
  output logic [PCS_W-1:0]   pc_src,
  output logic [ALUOP_W-1:0] alu_op,
  output logic [WBS_W-1:0]   wb_sel,
  output logic               hi_ld,
  output logic               lo_ld
);
  iclass_t cls;
  logic    zext;
  state_t  state_q;
  ctrl_t   cw;

  mc_classify u_cls (.opcode(opcode), .funct(funct), .rt_sel(rt_sel), .cls(cls), .zext(zext));
  mc_sequencer u_seq (.clk(clk), .rst_n(rst_n), .cls(cls), .state(state_q));
  mc_outdec u_dec (.state(state_q), .zext(zext), .cw(cw));

  assign pc_wr         = cw.pc_wr;
  assign pc_wr_cond    = cw.pc_wr_cond;
  assign pc_load       = cw.pc_wr | (cw.pc_wr_cond & br_taken);
  assign addr_from_alu = cw.iord;
  assign mem_rd        = cw.mem_rd;
  assign mem_wr        = cw.mem_wr;
  assign ir_wr         = cw.ir_wr;
  assign reg_wr        = cw.reg_wr;
  assign dst_is_rd     = cw.dst_rd;
  assign dst_link31    = cw.link31;
  assign imm_signed    = cw.imm_signed;
  assign srca_is_reg   = cw.srca_reg;
  assign srcb_sel      = cw.srcb;
  assign pc_src        = cw.pc_src;
  assign alu_op        = cw.alu_op;
  assign wb_sel        = cw.wb_sel;
  assign hi_ld         = cw.hi_ld;
  assign lo_ld         = cw.lo_ld;
endmodule

// File: rtl/mc_main_ctrl_chk.sv
module mc_main_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               br_taken,
  input logic               pc_wr,
  input logic               pc_wr_cond,
  input logic               pc_load,
  input logic               addr_from_alu,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               ir_wr,
  input logic               reg_wr,
  input logic               dst_link31,
  input logic [WBS_W-1:0]   wb_sel,
  input logic               hi_ld,
  input logic               lo_ld,
  input state_t             state
);
  // R14
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R14
  pc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load == (pc_wr || (pc_wr_cond && br_taken)));
  // R2
  fetch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !addr_from_alu) |=> (ir_wr && pc_wr && !mem_rd));
  // R5
  load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_from_alu) |=> (!mem_rd && addr_from_alu) ##1 (reg_wr && wb_sel == WB_MDR));
  // R9
  link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_link31 |-> (reg_wr && pc_wr && wb_sel == WB_PC));
  // R11
  hilo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ld |-> (lo_ld && !reg_wr));
  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT) |=> (state == S_HALT && !pc_wr && !pc_wr_cond && !mem_wr && !reg_wr
                           && !ir_wr && !hi_ld));
endmodule

bind mc_main_ctrl mc_main_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .pc_load(pc_load), .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .ir_wr(ir_wr), .reg_wr(reg_wr), .dst_link31(dst_link31), .wb_sel(wb_sel),
  .hi_ld(hi_ld), .lo_ld(lo_ld), .state(state_q)
);

// File: tb/mc_main_ctrl_tb.sv
module mc_main_ctrl_tb;
  import mc_ctrl_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, br_taken;
  logic [5:0] opcode, funct;
  logic [4:0] rt_sel;
  logic pc_wr, pc_wr_cond, pc_load, addr_from_alu, mem_rd, mem_wr, ir_wr, reg_wr;
  logic dst_is_rd, dst_link31, imm_signed, srca_is_reg, hi_ld, lo_ld;
  logic [1:0] srcb_sel, pc_src;
  logic [2:0] alu_op, wb_sel;

  int checks = 0;
  int errors = 0;

  typedef struct { ctrl_t w; string tag; } exp_t;
  exp_t q[$];

  mc_main_ctrl u_dut (.*);

  function automatic ctrl_t mk(string s, logic sg);
    ctrl_t c = '0;
    case (s)
      "fetch":  c.mem_rd = 1;
      "fwait":  begin c.ir_wr = 1; c.pc_wr = 1; c.srcb = 2'd1; end
      "decode": begin c.srcb = 2'd3; c.imm_signed = 1; end
      "exec_r": begin c.srca_reg = 1; c.alu_op = 3'd1; end
      "wb_rd":  begin c.reg_wr = 1; c.dst_rd = 1; end
      "mult":   begin c.srca_reg = 1; c.alu_op = 3'd1; c.hi_ld = 1; c.lo_ld = 1; end
      "mfhi":   begin c.reg_wr = 1; c.dst_rd = 1; c.wb_sel = 3'd3; end
      "mflo":   begin c.reg_wr = 1; c.dst_rd = 1; c.wb_sel = 3'd2; end
      "jr":     begin c.srca_reg = 1; c.alu_op = 3'd4; c.pc_wr = 1; end
      "exec_i": begin c.srca_reg = 1; c.srcb = 2'd2; c.imm_signed = sg; c.alu_op = 3'd2; end
      "wb_rt":  c.reg_wr = 1;
      "addr":   begin c.srca_reg = 1; c.srcb = 2'd2; c.imm_signed = 1; end
      "rd":     begin c.mem_rd = 1; c.iord = 1; end
      "rwait":  c.iord = 1;
      "wb_mem": begin c.reg_wr = 1; c.wb_sel = 3'd1; end
      "wr":     begin c.mem_wr = 1; c.iord = 1; end
      "branch": begin c.srca_reg = 1; c.alu_op = 3'd3; c.pc_wr_cond = 1; c.pc_src = 2'd1; end
      "jump":   begin c.pc_wr = 1; c.pc_src = 2'd2; end
      "jal":    begin c.pc_wr = 1; c.pc_src = 2'd2; c.reg_wr = 1; c.link31 = 1; c.wb_sel = 3'd4; end
      default:  c = '0;
    endcase
    return c;
  endfunction

  task automatic push(string s, string tag, logic sg = 1'b1);
    exp_t e;
    e.w = mk(s, sg);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(ctrl_t e, string tag);
    ctrl_t a;
    logic exp_load;
    #1;
    a = '{pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr, reg_wr, dst_is_rd,
          dst_link31, imm_signed, srca_is_reg, srcb_sel, pc_src, alu_op, wb_sel, hi_ld, lo_ld};
    exp_load = e.pc_wr | (e.pc_wr_cond & br_taken);
    checks++;
    if (a !== e || pc_load !== exp_load) begin
      errors++;
      $display("FAIL %s: act %h load %b, exp %h load %b", tag, a, pc_load, e, exp_load);
    end
  endtask

  task automatic run(logic [5:0] op, logic [5:0] fn, logic [4:0] rt, logic taken, string tag);
    opcode = op; funct = fn; rt_sel = rt; br_taken = taken;
    q.delete();
    push("fetch", "R2"); push("fwait", "R2"); push("decode", "R2");
    if (op == 6'h00) begin
      if (fn == 6'h08) push("jr", tag);
      else if (fn == 6'h10) push("mfhi", tag);
      else if (fn == 6'h12) push("mflo", tag);
      else if (fn == 6'h18 || fn == 6'h19) push("mult", tag);
      else begin push("exec_r", tag); push("wb_rd", tag); end
    end else if (op inside {6'h09, 6'h10, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E}) begin
      push("exec_i", tag, !(op inside {6'h0C, 6'h0D, 6'h0E}));
      push("wb_rt", tag);
    end else if (op == 6'h23) begin
      push("addr", tag); push("rd", tag); push("rwait", tag); push("wb_mem", tag);
    end else if (op == 6'h2B) begin
      push("addr", tag); push("wr", tag);
    end else if ((op >= 6'h04 && op <= 6'h07) || (op == 6'h01 && rt <= 5'd1)) push("branch", tag);
    else if (op == 6'h02) push("jump", tag);
    else if (op == 6'h03) push("jal", tag);
    else if (op == 6'h3F) for (int k = 0; k < 6; k++) push("halt", tag);
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      check(e.w, e.tag);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check(mk("fetch", 1'b0), "R1");
      @(negedge clk);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #40000;
    $display("FAIL watchdog: run did not complete");
    errors++;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = '0; funct = '0; rt_sel = '0; br_taken = 1'b0;
    @(negedge clk);
    do_reset();
    run(6'h00, 6'h21, 5'd0, 1'b0, "R3");   // register add
    run(6'h00, 6'h00, 5'd0, 1'b0, "R3");   // shift, function 0
    run(6'h09, 6'h00, 5'd0, 1'b0, "R4");   // signed immediate add
    run(6'h0C, 6'h3F, 5'd0, 1'b0, "R4");   // logical, zero-extended
    run(6'h0B, 6'h00, 5'd0, 1'b0, "R4");   // unsigned compare, still sign-extended
    run(6'h23, 6'h00, 5'd0, 1'b0, "R5");
    run(6'h2B, 6'h00, 5'd0, 1'b1, "R6");
    run(6'h04, 6'h00, 5'd0, 1'b1, "R7");   // taken
    run(6'h05, 6'h00, 5'd0, 1'b0, "R7");   // not taken
    run(6'h01, 6'h00, 5'd1, 1'b1, "R7");   // rt 1 under 0x01
    run(6'h01, 6'h00, 5'd5, 1'b1, "R13");  // rt 5 under 0x01 rejected
    run(6'h02, 6'h00, 5'd0, 1'b0, "R8");
    run(6'h03, 6'h00, 5'd0, 1'b0, "R9");
    run(6'h00, 6'h08, 5'd0, 1'b0, "R10");
    run(6'h00, 6'h18, 5'd0, 1'b0, "R11");
    run(6'h00, 6'h12, 5'd0, 1'b0, "R11");
    run(6'h00, 6'h10, 5'd0, 1'b0, "R11");
    run(6'h3E, 6'h00, 5'd0, 1'b1, "R13");
    run(6'h3F, 6'h00, 5'd0, 1'b1, "R12");
    do_reset();
    run(6'h0D, 6'h00, 5'd0, 1'b0, "R4");
    run(6'h00, 6'h19, 5'd0, 1'b0, "R11");
    run(6'h07, 6'h00, 5'd0, 1'b1, "R7");
    run(6'h3F, 6'h00, 5'd0, 1'b0, "R12");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule